// File: doc/BRIEF.md
# AXI-Lite Request/Response Master

This block sits between a client that speaks plain valid/ready handshakes and an AXI-Lite slave. The client hands over read addresses, write addresses and write data through three separate request ports. The block queues each one and presents it on the matching AXI-Lite channel. Read data with its two-bit status, and write status alone, come back on the slave's read-data and write-response channels. They are captured in small buffers and handed to the client through two result ports, in the order the requests were issued.

Each request port keeps its own in-flight count. The count goes up when the client's request is accepted. It goes down when the client takes the result that belongs to that request. Write address and write data both count down on a taken write result. A port stops accepting once two transfers are in flight, so no channel ever has more than a two-deep window. The data width is a parameter restricted to 32 or 64 bits, and the address width is a parameter. Both default to 64.

Top module: `axil_req_master`

## Requirements
- R1: The read-request port is ready only while fewer than two reads are in flight. A read is in flight from its acceptance on the read-request port until its result is taken on the read-result port.
- R2: The write-address and write-data request ports keep separate in-flight counts, each limited to two. Each count rises on its own port's acceptance and falls when a write result is taken, never going below zero. Filling one port does not block the other.
- R3: ARVALID, AWVALID and WVALID are driven from a queue. Once VALID is raised, it stays high with the payload held stable until READY is sampled. Queued requests go out in acceptance order, and the next one is presented in the cycle right after a handshake.
- R4: The read-result port is valid only while a captured read response has not been taken. It returns RDATA unchanged, with RRESP as a 2-bit code (0 okay, 1 exclusive okay, 2 slave error, 3 decode error), in issue order.
- R5: The write-result port is valid only while a captured write response has not been taken. It returns only the 2-bit BRESP code, in issue order.
- R6: RREADY and BREADY are high exactly while their two-entry result buffer has a free slot. Both are therefore high after reset and low once two results are waiting.
- R7: WSTRB is all ones on every write, and ARPROT and AWPROT are always zero.
- R8: After reset, no AXI VALID and no result-port valid is asserted, and all three request ports are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Client offers a read address |
| rd_req_ready | output | 1 | Read address accepted this cycle if valid |
| rd_req_addr | input | ADDR_W | Read address |
| wa_req_valid | input | 1 | Client offers a write address |
| wa_req_ready | output | 1 | Write address can be accepted |
| wa_req_addr | input | ADDR_W | Write address |
| wd_req_valid | input | 1 | Client offers write data |
| wd_req_ready | output | 1 | Write data can be accepted |
| wd_req_data | input | DATA_W | Write data |
| rd_rsp_valid | output | 1 | A read result is waiting |
| rd_rsp_ready | input | 1 | Client takes the read result |
| rd_rsp_data | output | DATA_W | Read data |
| rd_rsp_code | output | 2 | Read response code |
| wr_rsp_valid | output | 1 | A write result is waiting |
| wr_rsp_ready | input | 1 | Client takes the write result |
| wr_rsp_code | output | 2 | Write response code |
| m_araddr | output | ADDR_W | AXI read address |
| m_arprot | output | 3 | AXI read protection (zero) |
| m_arvalid | output | 1 | AXI read address valid |
| m_arready | input | 1 | AXI read address ready |
| m_rdata | input | DATA_W | AXI read data |
| m_rresp | input | 2 | AXI read response |
| m_rvalid | input | 1 | AXI read data valid |
| m_rready | output | 1 | AXI read data ready |
| m_awaddr | output | ADDR_W | AXI write address |
| m_awprot | output | 3 | AXI write protection (zero) |
| m_awvalid | output | 1 | AXI write address valid |
| m_awready | input | 1 | AXI write address ready |
| m_wdata | output | DATA_W | AXI write data |
| m_wstrb | output | DATA_W/8 | AXI write strobes (all ones) |
| m_wvalid | output | 1 | AXI write data valid |
| m_wready | input | 1 | AXI write data ready |
| m_bresp | input | 2 | AXI write response |
| m_bvalid | input | 1 | AXI write response valid |
| m_bready | output | 1 | AXI write response ready |

## Verification
The bench builds the block with its default parameters: 64-bit data and 64-bit addresses. With these values, address patterns that use the upper 32 bits and data that uses every byte lane are checked to pass through unchanged. The all-ones check on the strobes covers the full eight-lane width. With the window of two, both the "one in flight, still ready" case and the "two in flight, blocked" case are reached on every request port.

// File: rtl/axil_master_pkg.sv
package axil_master_pkg;
  typedef logic [1:0] resp_t;

  localparam resp_t RESP_OKAY   = 2'd0;
  localparam resp_t RESP_EXOKAY = 2'd1;
  localparam resp_t RESP_SLVERR = 2'd2;
  localparam resp_t RESP_DECERR = 2'd3;

  // In-flight window per request channel.
  localparam int unsigned WINDOW = 2;

  // Ring pointer advance with wrap at depth-1.
  function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
    return (ptr + 1 >= depth) ? 0 : ptr + 1;
  endfunction

  // In-flight count update: add an acceptance, remove a taken result (never below zero).
  function automatic int unsigned flight_next(input int unsigned cnt, input logic inc, input logic dec);
    int unsigned n;
    n = cnt + (inc ? 1 : 0);
    if (dec && n != 0) n = n - 1;
    return n;
  endfunction
endpackage

// File: rtl/axil_ring.sv
module axil_ring #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  import axil_master_pkg::*;

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] level_q;
  logic          push_fire, pop_fire;

  assign full      = (level_q == CW'(DEPTH));
  assign empty     = (level_q == '0);
  assign push_fire = push && !full;
  assign pop_fire  = pop && !empty;
  assign head      = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (push_fire) wr_q <= PW'(ring_next(int'(wr_q), DEPTH));
      if (pop_fire)  rd_q <= PW'(ring_next(int'(rd_q), DEPTH));
      level_q <= CW'(int'(level_q) + (push_fire ? 1 : 0) - (pop_fire ? 1 : 0));
    end
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem_q[wr_q] <= din;
  end

  // R6
  ring_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |-> pop)
    else $error("ring written while full");
endmodule

// File: rtl/axil_req_chan.sv
module axil_req_chan #(
  parameter int unsigned W     = 8,
  parameter int unsigned LIMIT = axil_master_pkg::WINDOW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_payload,
  input  logic         rsp_taken,
  output logic         axi_valid,
  input  logic         axi_ready,
  output logic [W-1:0] axi_payload
);
  import axil_master_pkg::*;

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          req_fire, send_fire, q_full, q_empty;

  assign req_ready = (int'(cnt_q) < int'(LIMIT));
  assign req_fire  = req_valid && req_ready;
  assign axi_valid = !q_empty;
  assign send_fire = axi_valid && axi_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CW'(flight_next(int'(cnt_q), req_fire, rsp_taken));
  end

  axil_ring #(.W(W), .DEPTH(LIMIT)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_fire),
    .din   (req_payload),
    .pop   (send_fire),
    .head  (axi_payload),
    .full  (q_full),
    .empty (q_empty)
  );

  // R1 R2
  window_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= int'(LIMIT))
    else $error("in-flight count above window");

  // R1 R2
  accept_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> !q_full)
    else $error("request accepted with full queue");

  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    axi_valid && !axi_ready |=> axi_valid && $stable(axi_payload))
    else $error("VALID or payload changed before READY");
endmodule

// File: rtl/axil_req_master.sv
module axil_req_master #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req_valid,
  output logic                rd_req_ready,
  input  logic [ADDR_W-1:0]   rd_req_addr,
  input  logic                wa_req_valid,
  output logic                wa_req_ready,
  input  logic [ADDR_W-1:0]   wa_req_addr,
  input  logic                wd_req_valid,
  output logic                wd_req_ready,
  input  logic [DATA_W-1:0]   wd_req_data,
  output logic                rd_rsp_valid,
  input  logic                rd_rsp_ready,
  output logic [DATA_W-1:0]   rd_rsp_data,
  output logic [1:0]          rd_rsp_code,
  output logic                wr_rsp_valid,
  input  logic                wr_rsp_ready,
  output logic [1:0]          wr_rsp_code,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [2:0]          m_arprot,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [2:0]          m_awprot,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready
);
  import axil_master_pkg::*;

  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned RBUF_W = DATA_W + 2;

  logic              rd_taken, wr_taken;
  logic              rbuf_full, rbuf_empty, bbuf_full, bbuf_empty;
  logic [RBUF_W-1:0] rbuf_head;

  assign rd_taken = rd_rsp_valid && rd_rsp_ready;
  assign wr_taken = wr_rsp_valid && wr_rsp_ready;

  assign m_arprot = 3'b000;
  assign m_awprot = 3'b000;
  assign m_wstrb  = {STRB_W{1'b1}};

  axil_req_chan #(.W(ADDR_W)) u_ar (
    .clk(clk), .rst_n(rst_n),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_payload(rd_req_addr),
    .rsp_taken(rd_taken),
    .axi_valid(m_arvalid), .axi_ready(m_arready), .axi_payload(m_araddr)
  );

  axil_req_chan #(.W(ADDR_W)) u_aw (
    .clk(clk), .rst_n(rst_n),
    .req_valid(wa_req_valid), .req_ready(wa_req_ready), .req_payload(wa_req_addr),
    .rsp_taken(wr_taken),
    .axi_valid(m_awvalid), .axi_ready(m_awready), .axi_payload(m_awaddr)
  );

  axil_req_chan #(.W(DATA_W)) u_w (
    .clk(clk), .rst_n(rst_n),
    .req_valid(wd_req_valid), .req_ready(wd_req_ready), .req_payload(wd_req_data),
    .rsp_taken(wr_taken),
    .axi_valid(m_wvalid), .axi_ready(m_wready), .axi_payload(m_wdata)
  );

  // Read results: {code, data}
  assign m_rready = !rbuf_full;
  axil_ring #(.W(RBUF_W), .DEPTH(WINDOW)) u_rbuf (
    .clk(clk), .rst_n(rst_n),
    .push(m_rvalid && m_rready), .din({m_rresp, m_rdata}),
    .pop(rd_taken), .head(rbuf_head), .full(rbuf_full), .empty(rbuf_empty)
  );
  assign rd_rsp_valid = !rbuf_empty;
  assign rd_rsp_data  = rbuf_head[DATA_W-1:0];
  assign rd_rsp_code  = rbuf_head[RBUF_W-1 -: 2];

  // Write results: code only
  assign m_bready = !bbuf_full;
  axil_ring #(.W(2), .DEPTH(WINDOW)) u_bbuf (
    .clk(clk), .rst_n(rst_n),
    .push(m_bvalid && m_bready), .din(m_bresp),
    .pop(wr_taken), .head(wr_rsp_code), .full(bbuf_full), .empty(bbuf_empty)
  );
  assign wr_rsp_valid = !bbuf_empty;

  // R4
  rd_result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && !rd_rsp_ready |=> rd_rsp_valid && $stable(rd_rsp_data) && $stable(rd_rsp_code))
    else $error("read result changed before taken");

  // R5
  wr_result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rsp_valid && !wr_rsp_ready |=> wr_rsp_valid && $stable(wr_rsp_code))
    else $error("write result changed before taken");

  // R6
  rready_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rvalid && m_rready && !rd_rsp_valid |=> rd_rsp_valid)
    else $error("accepted read response not captured");
endmodule

// File: tb/test_axil_req_master.sv
module test_axil_req_master;
  localparam int unsigned DW = 64;
  localparam int unsigned AW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          rd_req_valid = 0, rd_req_ready;
  logic [AW-1:0] rd_req_addr = '0;
  logic          wa_req_valid = 0, wa_req_ready;
  logic [AW-1:0] wa_req_addr = '0;
  logic          wd_req_valid = 0, wd_req_ready;
  logic [DW-1:0] wd_req_data = '0;
  logic          rd_rsp_valid, rd_rsp_ready = 0;
  logic [DW-1:0] rd_rsp_data;
  logic [1:0]    rd_rsp_code;
  logic          wr_rsp_valid, wr_rsp_ready = 0;
  logic [1:0]    wr_rsp_code;
  logic [AW-1:0] m_araddr;
  logic [2:0]    m_arprot;
  logic          m_arvalid, m_arready = 0;
  logic [DW-1:0] m_rdata = '0;
  logic [1:0]    m_rresp = '0;
  logic          m_rvalid = 0, m_rready;
  logic [AW-1:0] m_awaddr;
  logic [2:0]    m_awprot;
  logic          m_awvalid, m_awready = 0;
  logic [DW-1:0] m_wdata;
  logic [DW/8-1:0] m_wstrb;
  logic          m_wvalid, m_wready = 0;
  logic [1:0]    m_bresp = '0;
  logic          m_bvalid = 0, m_bready;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  axil_req_master #(.DATA_W(DW), .ADDR_W(AW)) i_axil_req_master (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .wa_req_valid(wa_req_valid), .wa_req_ready(wa_req_ready), .wa_req_addr(wa_req_addr),
    .wd_req_valid(wd_req_valid), .wd_req_ready(wd_req_ready), .wd_req_data(wd_req_data),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_code(rd_rsp_code),
    .wr_rsp_valid(wr_rsp_valid), .wr_rsp_ready(wr_rsp_ready), .wr_rsp_code(wr_rsp_code),
    .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    // R8 R6
    chk("R8", "rd_req_ready", 64'(rd_req_ready), 1);
    chk("R8", "wa_req_ready", 64'(wa_req_ready), 1);
    chk("R8", "wd_req_ready", 64'(wd_req_ready), 1);
    chk("R8", "arvalid", 64'(m_arvalid), 0);
    chk("R8", "awvalid", 64'(m_awvalid), 0);
    chk("R8", "wvalid", 64'(m_wvalid), 0);
    chk("R8", "rd_rsp_valid", 64'(rd_rsp_valid), 0);
    chk("R8", "wr_rsp_valid", 64'(wr_rsp_valid), 0);
    chk("R6", "rready after reset", 64'(m_rready), 1);
    chk("R6", "bready after reset", 64'(m_bready), 1);
  endtask

  task automatic t_single_read;
    rd_req_valid = 1; rd_req_addr = 64'hF00D_0000_1234_5678;
    step; rd_req_valid = 0;
    chk("R3", "arvalid raised", 64'(m_arvalid), 1);
    chk("R3", "araddr", m_araddr, 64'hF00D_0000_1234_5678);
    chk("R7", "arprot", 64'(m_arprot), 0);
    chk("R1", "ready with one in flight", 64'(rd_req_ready), 1);
    m_arready = 1;
    step; m_arready = 0;
    chk("R3", "arvalid dropped after handshake", 64'(m_arvalid), 0);
    m_rvalid = 1; m_rdata = 64'hDEAD_BEEF_CAFE_0123; m_rresp = 2'd2;
    step; m_rvalid = 0;
    chk("R4", "rd_rsp_valid", 64'(rd_rsp_valid), 1);
    chk("R4", "rd_rsp_data", rd_rsp_data, 64'hDEAD_BEEF_CAFE_0123);
    chk("R4", "rd_rsp_code slave error", 64'(rd_rsp_code), 2);
    rd_rsp_ready = 1;
    step; rd_rsp_ready = 0;
    chk("R4", "rd_rsp_valid cleared", 64'(rd_rsp_valid), 0);
    chk("R1", "ready after take", 64'(rd_req_ready), 1);
  endtask

  task automatic t_read_limit;
    rd_req_valid = 1; rd_req_addr = 64'h8000_0000_0000_0A00;
    step;
    rd_req_addr = 64'h0000_0001_0000_0B00;
    step; rd_req_valid = 0;
    chk("R1", "blocked at two in flight", 64'(rd_req_ready), 0);
    chk("R3", "first address presented", m_araddr, 64'h8000_0000_0000_0A00);
    step;
    chk("R3", "address held without ready", m_araddr, 64'h8000_0000_0000_0A00);
    chk("R3", "valid held without ready", 64'(m_arvalid), 1);
    m_arready = 1;
    step;
    chk("R3", "second address next cycle", m_araddr, 64'h0000_0001_0000_0B00);
    chk("R3", "valid stays for queued", 64'(m_arvalid), 1);
    step; m_arready = 0;
    chk("R3", "queue drained", 64'(m_arvalid), 0);
    chk("R1", "still blocked before results taken", 64'(rd_req_ready), 0);
    m_rvalid = 1; m_rdata = 64'h1111_2222_3333_4444; m_rresp = 2'd0;
    chk("R6", "rready with empty buffer", 64'(m_rready), 1);
    step;
    m_rdata = 64'h5555_6666_7777_8888; m_rresp = 2'd1;
    chk("R6", "rready with one slot free", 64'(m_rready), 1);
    step; m_rvalid = 0;
    chk("R6", "rready low when buffer full", 64'(m_rready), 0);
    chk("R4", "first result in order", rd_rsp_data, 64'h1111_2222_3333_4444);
    chk("R4", "first code okay", 64'(rd_rsp_code), 0);
    rd_rsp_ready = 1;
    step; rd_rsp_ready = 0;
    chk("R4", "second result in order", rd_rsp_data, 64'h5555_6666_7777_8888);
    chk("R4", "second code exclusive okay", 64'(rd_rsp_code), 1);
    chk("R1", "ready after one result taken", 64'(rd_req_ready), 1);
    chk("R6", "rready after slot freed", 64'(m_rready), 1);
    rd_rsp_ready = 1;
    step; rd_rsp_ready = 0;
    chk("R4", "buffer empty", 64'(rd_rsp_valid), 0);
  endtask

  task automatic t_single_write;
    m_awready = 1; m_wready = 1;
    wa_req_valid = 1; wa_req_addr = 64'hA5A5_0000_FFFF_0010;
    wd_req_valid = 1; wd_req_data = 64'h0123_4567_89AB_CDEF;
    step; wa_req_valid = 0; wd_req_valid = 0;
    chk("R3", "awvalid", 64'(m_awvalid), 1);
    chk("R3", "awaddr", m_awaddr, 64'hA5A5_0000_FFFF_0010);
    chk("R3", "wvalid", 64'(m_wvalid), 1);
    chk("R3", "wdata", m_wdata, 64'h0123_4567_89AB_CDEF);
    chk("R7", "wstrb all ones", 64'(m_wstrb), 64'hFF);
    chk("R7", "awprot", 64'(m_awprot), 0);
    step; m_awready = 0; m_wready = 0;
    chk("R3", "awvalid dropped", 64'(m_awvalid), 0);
    chk("R3", "wvalid dropped", 64'(m_wvalid), 0);
    m_bvalid = 1; m_bresp = 2'd3;
    step; m_bvalid = 0;
    chk("R5", "wr_rsp_valid", 64'(wr_rsp_valid), 1);
    chk("R5", "wr_rsp_code decode error", 64'(wr_rsp_code), 3);
    wr_rsp_ready = 1;
    step; wr_rsp_ready = 0;
    chk("R5", "wr_rsp_valid cleared", 64'(wr_rsp_valid), 0);
  endtask

  task automatic t_write_limit;
    wa_req_valid = 1; wa_req_addr = 64'h0000_0000_0000_1000;
    step;
    wa_req_addr = 64'h0000_0000_0000_2000;
    step; wa_req_valid = 0;
    chk("R2", "write address blocked at two", 64'(wa_req_ready), 0);
    chk("R2", "write data independent", 64'(wd_req_ready), 1);
    wd_req_valid = 1; wd_req_data = 64'hFEED_FACE_0000_0001;
    step; wd_req_valid = 0;
    chk("R2", "write data ready with one in flight", 64'(wd_req_ready), 1);
    chk("R3", "first write address held", m_awaddr, 64'h0000_0000_0000_1000);
    m_awready = 1; m_wready = 1;
    step;
    chk("R3", "second write address next cycle", m_awaddr, 64'h0000_0000_0000_2000);
    chk("R3", "write data sent", 64'(m_wvalid), 0);
    step; m_awready = 0; m_wready = 0;
    chk("R3", "write address queue drained", 64'(m_awvalid), 0);
    m_bvalid = 1; m_bresp = 2'd1;
    step;
    m_bresp = 2'd0;
    step; m_bvalid = 0;
    chk("R6", "bready low when buffer full", 64'(m_bready), 0);
    chk("R5", "first write code", 64'(wr_rsp_code), 1);
    chk("R2", "still blocked before take", 64'(wa_req_ready), 0);
    wr_rsp_ready = 1;
    step; wr_rsp_ready = 0;
    chk("R5", "second write code in order", 64'(wr_rsp_code), 0);
    chk("R2", "write address ready after take", 64'(wa_req_ready), 1);
    chk("R6", "bready after slot freed", 64'(m_bready), 1);
    wr_rsp_ready = 1;
    step; wr_rsp_ready = 0;
    chk("R5", "write buffer empty", 64'(wr_rsp_valid), 0);
    chk("R2", "write address ready at zero", 64'(wa_req_ready), 1);
    chk("R2", "write data ready at zero", 64'(wd_req_ready), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step;
    rst_n = 1;
    step;
    t_reset;
    t_single_read;
    t_read_limit;
    t_single_write;
    t_write_limit;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule